// File: doc/BRIEF.md
# Partitioned Superstep Bitonic Sorter

This block runs one superstep of a bitonic sorting network over an array of `2^IDX_W` words held in an external memory. A superstep is a group of consecutive network steps. Each step compares item pairs whose indexes differ in a single bit position. The caller supplies those bit positions as a list, together with the network stage value that sets the sort direction. The engine splits the array into parts. All members of one part share the same value on every index bit that is not in the list. For each part it reads the items into a local buffer of `2^LOC_W` words, runs every listed step as compare-swaps inside the buffer, and writes the part back before it moves on. One memory round trip therefore covers several network steps.

An outside scheduler calls the engine once per superstep and chooses the lists. For good burst behaviour it puts the lowest index bits in the list set, adds further bits until the list is full, and arranges the entries in the order the network needs. Parts never share items, so no part depends on any other.

Top module: `ssBitonicEngine`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `memReq` are both 0.
- R2: A start with `cCount` equal to 0 or greater than `LOC_W` makes no memory access and raises `done` in the following cycle.
- R3: Item `e` of part `p` sits at the memory address built as follows. Bit `j` of `e` goes to index bit `cList[j]`, where list entry `j` occupies `cList[j*POS_W +: POS_W]`. The bits of `p`, lowest first, fill the index positions missing from the list, from the lowest position upward.
- R4: Parts are handled in ascending part number. For each part, the engine reads all `2^cCount` items in element order 0 upward, then writes them all back in the same order. Only then does the next part's first read go out. Reads have `memWe`=0 and writes have `memWe`=1.
- R5: Inside a part, the list entries are processed from index 0 upward. For entry `j`, the pairs are formed by putting a 0 and a 1 at bit `j` of every pair count below `2^(cCount-1)`. Each pair is compare-swapped, and every later step sees the results of the earlier ones.
- R6: A pair sorts ascending (smaller value at the element with the 0 bit) when bit `stage` of that element's global index is 0, or when `stage` is at least `IDX_W`. Otherwise the pair sorts descending.
- R7: A valid superstep reads and writes every one of the `2^IDX_W` addresses exactly once. No access happens outside a superstep.
- R8: `done` is high for exactly one cycle, in the cycle after the last write is acknowledged, and `memReq` is 0 while `done` is high.
- R9: Supersteps for stages 1 to `IDX_W`, each with its steps in descending bit order, leave the memory sorted ascending.
- R10: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and (for writes) `memWdata` unchanged until the cycle in which `memValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a superstep; ignored while busy |
| stage | input | STG_W | Network stage value that picks the sort direction |
| cCount | input | CNT_W | Number of valid list entries |
| cList | input | LOC_W*POS_W | Step bit positions; entry j at bits j*POS_W |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | IDX_W | Item index being accessed |
| memWdata | output | DATA_W | Data for a write |
| memValid | input | 1 | Access acknowledged; carries read data for reads |
| memRdata | input | DATA_W | Read data, valid with memValid |

## Verification
The hardest case to reach is a part whose members are spread across scattered index bits, with the sort direction changing from one part to the next. This happens only when the list names high, non-adjacent positions and the stage bit falls on a part bit. The stimulus sends lists such as {3,1} at stage 2 and {2,0,3} at stage 1. A scoreboard model predicts every read address and every written value for these cases, so a wrong scatter or a wrong direction shows up as a mismatched transaction. A full stage-by-stage sort then confirms that the outcome is sorted.

// File: rtl/ssSortPkg.sv
package ssSortPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SORT,
    ST_FLUSH,
    ST_DONE
  } ssState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic swapEn;
  } ssStrobe_t;
endpackage

// File: rtl/ssCtrl.sv
module ssCtrl import ssSortPkg::*; #(
  parameter int IDX_W = 4,
  parameter int LOC_W = 3,
  parameter int POS_W = 2,
  parameter int CNT_W = 3,
  parameter int STG_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [STG_W-1:0]       stage,
  input  logic [CNT_W-1:0]       cCount,
  input  logic [LOC_W*POS_W-1:0] cList,
  input  logic                   memValid,
  output ssStrobe_t              strobe,
  output logic                   done,
  output logic                   memReq,
  output logic                   memWe,
  output logic [IDX_W-1:0]       partIdx,
  output logic [LOC_W-1:0]       elemIdx,
  output logic [CNT_W-1:0]       stepIdx,
  output logic [LOC_W-1:0]       pairIdx,
  output logic [LOC_W*POS_W-1:0] cfgList,
  output logic [CNT_W-1:0]       cfgCount,
  output logic [STG_W-1:0]       cfgStage
);
  ssState_t state;
  logic [LOC_W:0] elemLast;
  logic [LOC_W:0] pairLast;
  logic [IDX_W:0] partLast;
  logic           badCount;
  logic           elemAtEnd;

  assign elemLast  = ((LOC_W+1)'(1) << cfgCount) - (LOC_W+1)'(1);
  assign pairLast  = elemLast >> 1;
  assign partLast  = ((IDX_W+1)'(1) << (CNT_W'(IDX_W) - cfgCount)) - (IDX_W+1)'(1);
  assign badCount  = (cCount == '0) || (cCount > CNT_W'(LOC_W));
  assign elemAtEnd = ({1'b0, elemIdx} == elemLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      partIdx  <= '0;
      elemIdx  <= '0;
      stepIdx  <= '0;
      pairIdx  <= '0;
      cfgList  <= '0;
      cfgCount <= '0;
      cfgStage <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cfgList  <= cList;
          cfgCount <= cCount;
          cfgStage <= stage;
          partIdx  <= '0;
          elemIdx  <= '0;
          state    <= badCount ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: if (memValid) begin
          if (elemAtEnd) begin
            stepIdx <= '0;
            pairIdx <= '0;
            state   <= ST_SORT;
          end else begin
            elemIdx <= elemIdx + 1'b1;
          end
        end
        ST_SORT: begin
          if ({1'b0, pairIdx} == pairLast) begin
            pairIdx <= '0;
            if (stepIdx == cfgCount - 1'b1) begin
              elemIdx <= '0;
              state   <= ST_FLUSH;
            end else begin
              stepIdx <= stepIdx + 1'b1;
            end
          end else begin
            pairIdx <= pairIdx + 1'b1;
          end
        end
        ST_FLUSH: if (memValid) begin
          if (elemAtEnd) begin
            elemIdx <= '0;
            if ({1'b0, partIdx} == partLast) begin
              state <= ST_DONE;
            end else begin
              partIdx <= partIdx + 1'b1;
              state   <= ST_FETCH;
            end
          end else begin
            elemIdx <= elemIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.loadEn = (state == ST_FETCH) && memValid;
  assign strobe.swapEn = (state == ST_SORT);
  assign memReq        = (state == ST_FETCH) || (state == ST_FLUSH);
  assign memWe         = (state == ST_FLUSH);
  assign done          = (state == ST_DONE);
endmodule

// File: rtl/ssDatapath.sv
module ssDatapath import ssSortPkg::*; #(
  parameter int IDX_W  = 4,
  parameter int LOC_W  = 3,
  parameter int DATA_W = 16,
  parameter int POS_W  = 2,
  parameter int CNT_W  = 3,
  parameter int STG_W  = 3
) (
  input  logic                   clk,
  input  ssStrobe_t              strobe,
  input  logic [IDX_W-1:0]       partIdx,
  input  logic [LOC_W-1:0]       elemIdx,
  input  logic [CNT_W-1:0]       stepIdx,
  input  logic [LOC_W-1:0]       pairIdx,
  input  logic [LOC_W*POS_W-1:0] cfgList,
  input  logic [CNT_W-1:0]       cfgCount,
  input  logic [STG_W-1:0]       cfgStage,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [IDX_W-1:0]       memAddr,
  output logic [DATA_W-1:0]      memWdata
);
  localparam int DEPTH = 1 << LOC_W;

  logic [DATA_W-1:0] locBuf [DEPTH];

  // Global index of element elem in part part
  function automatic logic [IDX_W-1:0] scatter(
    input logic [IDX_W-1:0]       part,
    input logic [LOC_W-1:0]       elem,
    input logic [LOC_W*POS_W-1:0] lst,
    input logic [CNT_W-1:0]       cnt
  );
    logic [IDX_W-1:0] inList;
    logic [IDX_W-1:0] addr;
    logic [POS_W-1:0] pos;
    int               k;
    inList = '0;
    addr   = '0;
    k      = 0;
    for (int j = 0; j < LOC_W; j++) begin
      if (CNT_W'(j) < cnt) begin
        pos         = lst[j*POS_W +: POS_W];
        inList[pos] = 1'b1;
        addr[pos]   = elem[j];
      end
    end
    for (int b = 0; b < IDX_W; b++) begin
      if (!inList[b]) begin
        addr[b] = part[k];
        k++;
      end
    end
    return addr;
  endfunction

  logic [LOC_W-1:0]  lowMask;
  logic [LOC_W-1:0]  loIdx;
  logic [LOC_W-1:0]  hiIdx;
  logic [IDX_W-1:0]  loGlobal;
  logic [IDX_W-1:0]  stageBits;
  logic              ascend;
  logic              needSwap;
  logic [DATA_W-1:0] loVal;
  logic [DATA_W-1:0] hiVal;

  always_comb begin
    lowMask   = (LOC_W'(1) << stepIdx) - LOC_W'(1);
    loIdx     = ((pairIdx & ~lowMask) << 1) | (pairIdx & lowMask);
    hiIdx     = loIdx | (LOC_W'(1) << stepIdx);
    loGlobal  = scatter(partIdx, loIdx, cfgList, cfgCount);
    stageBits = loGlobal >> cfgStage;
    ascend    = ~stageBits[0];
    loVal     = locBuf[loIdx];
    hiVal     = locBuf[hiIdx];
    needSwap  = ascend ? (loVal > hiVal) : (loVal < hiVal);
  end

  always_ff @(posedge clk) begin
    if (strobe.loadEn) begin
      locBuf[elemIdx] <= memRdata;
    end else if (strobe.swapEn && needSwap) begin
      locBuf[loIdx] <= hiVal;
      locBuf[hiIdx] <= loVal;
    end
  end

  assign memAddr  = scatter(partIdx, elemIdx, cfgList, cfgCount);
  assign memWdata = locBuf[elemIdx];
endmodule

// File: rtl/ssBitonicEngine.sv
module ssBitonicEngine import ssSortPkg::*; #(
  parameter int IDX_W  = 4,
  parameter int LOC_W  = 3,
  parameter int DATA_W = 16,
  localparam int POS_W = $clog2(IDX_W),
  localparam int CNT_W = $clog2(IDX_W + 2),
  localparam int STG_W = $clog2(IDX_W + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [STG_W-1:0]       stage,
  input  logic [CNT_W-1:0]       cCount,
  input  logic [LOC_W*POS_W-1:0] cList,
  output logic                   done,
  output logic                   memReq,
  output logic                   memWe,
  output logic [IDX_W-1:0]       memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic                   memValid,
  input  logic [DATA_W-1:0]      memRdata
);
  ssStrobe_t              strobe;
  logic [IDX_W-1:0]       partIdx;
  logic [LOC_W-1:0]       elemIdx;
  logic [CNT_W-1:0]       stepIdx;
  logic [LOC_W-1:0]       pairIdx;
  logic [LOC_W*POS_W-1:0] cfgList;
  logic [CNT_W-1:0]       cfgCount;
  logic [STG_W-1:0]       cfgStage;

  ssCtrl #(
    .IDX_W(IDX_W), .LOC_W(LOC_W), .POS_W(POS_W), .CNT_W(CNT_W), .STG_W(STG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stage(stage), .cCount(cCount),
    .cList(cList), .memValid(memValid), .strobe(strobe), .done(done),
    .memReq(memReq), .memWe(memWe), .partIdx(partIdx), .elemIdx(elemIdx),
    .stepIdx(stepIdx), .pairIdx(pairIdx), .cfgList(cfgList),
    .cfgCount(cfgCount), .cfgStage(cfgStage)
  );

  ssDatapath #(
    .IDX_W(IDX_W), .LOC_W(LOC_W), .DATA_W(DATA_W), .POS_W(POS_W),
    .CNT_W(CNT_W), .STG_W(STG_W)
  ) u_data (
    .clk(clk), .strobe(strobe), .partIdx(partIdx), .elemIdx(elemIdx),
    .stepIdx(stepIdx), .pairIdx(pairIdx), .cfgList(cfgList),
    .cfgCount(cfgCount), .cfgStage(cfgStage), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/ssBitonicChk.sv
module ssBitonicChk #(
  parameter int IDX_W  = 4,
  parameter int LOC_W  = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CNT_W-1:0]  cCount,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic [IDX_W-1:0]  memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memValid
);
  logic busyTrk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyTrk <= 1'b0;
    else if (done)  busyTrk <= 1'b0;
    else if (start) busyTrk <= 1'b1;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr) && $stable(memWe));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memValid |=> $stable(memWdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busyTrk && ((cCount == '0) || (cCount > CNT_W'(LOC_W))) |=> done && !memReq);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyTrk |-> !memReq);
endmodule

bind ssBitonicEngine ssBitonicChk #(
  .IDX_W(IDX_W), .LOC_W(LOC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .cCount(cCount), .done(done),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memValid(memValid)
);

// File: tb/ssBitonicEngine_bench.sv
module ssBitonicEngine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 4;
  localparam int LOC_W  = 3;
  localparam int DATA_W = 16;
  localparam int NITEMS = 1 << IDX_W;
  localparam int POS_W  = $clog2(IDX_W);
  localparam int CNT_W  = $clog2(IDX_W + 2);
  localparam int STG_W  = $clog2(IDX_W + 1);

  logic                   clk;
  logic                   rstN;
  logic                   start;
  logic [STG_W-1:0]       stage;
  logic [CNT_W-1:0]       cCount;
  logic [LOC_W*POS_W-1:0] cList;
  logic                   done;
  logic                   memReq;
  logic                   memWe;
  logic [IDX_W-1:0]       memAddr;
  logic [DATA_W-1:0]      memWdata;
  logic                   memValid;
  logic [DATA_W-1:0]      memRdata;

  logic [DATA_W-1:0] extMem [NITEMS];
  int                model  [NITEMS];

  typedef struct packed {
    logic              we;
    logic [IDX_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } txn_t;
  txn_t expQ[$];

  int  checks   = 0;
  int  errors   = 0;
  int  txnCnt   = 0;
  bit  finished = 0;

  ssBitonicEngine #(.IDX_W(IDX_W), .LOC_W(LOC_W), .DATA_W(DATA_W)) u_ssBitonicEngine (
    .clk(clk), .rstN(rstN), .start(start), .stage(stage), .cCount(cCount),
    .cList(cList), .done(done), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memValid(memValid),
    .memRdata(memRdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pushTxn(input bit we, input int a, input int d);
    txn_t x;
    x.we   = we;
    x.addr = IDX_W'(a);
    x.data = DATA_W'(d);
    expQ.push_back(x);
  endtask

  // Memory responder: one-cycle acknowledge per request
  initial begin
    memValid = 1'b0;
    memRdata = '0;
    forever begin
      @(posedge clk);
      if (memReq === 1'b1 && !memValid) begin
        memValid <= 1'b1;
        if (memWe) extMem[memAddr] <= memWdata;
        else       memRdata <= extMem[memAddr];
      end else begin
        memValid <= 1'b0;
      end
    end
  end

  // Monitor: pops the scoreboard on each acknowledged access
  initial begin
    bit               prevPend;
    logic [IDX_W-1:0] prevAddr;
    logic             prevWe;
    prevPend = 0;
    prevAddr = '0;
    prevWe   = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1) begin
        if (prevPend)
          check(memReq && memAddr == prevAddr && memWe == prevWe, "R10",
                "request changed before ack", int'(memAddr), int'(prevAddr));
        prevPend = memReq && !memValid;
        prevAddr = memAddr;
        prevWe   = memWe;
        if (memReq && memValid) begin
          txnCnt++;
          if (expQ.size() == 0) begin
            check(0, "R7", "unexpected access addr", int'(memAddr), -1);
          end else begin
            txn_t x;
            x = expQ.pop_front();
            check(memWe == x.we, "R4", "access kind", int'(memWe), int'(x.we));
            check(memAddr == x.addr, "R3", "access address", int'(memAddr), int'(x.addr));
            if (x.we)
              check(memWdata == x.data, "R5,R6", "written value", int'(memWdata), int'(x.data));
          end
        end
      end
    end
  end

  // Driver: predicts all traffic of one superstep, then runs it
  task automatic runSuper(input int stg, input int cnt, input int p0, input int p1, input int p2);
    int lst[3];
    int freeP[IDX_W];
    int nFree;
    int gi[1 << LOC_W];
    int v[1 << LOC_W];
    int base;
    int waitCyc;
    int t;
    int lo;
    int hi;
    bit asc;
    bit used;
    lst[0] = p0; lst[1] = p1; lst[2] = p2;
    base = txnCnt;
    if (cnt >= 1 && cnt <= LOC_W) begin
      nFree = 0;
      for (int b = 0; b < IDX_W; b++) begin
        used = 0;
        for (int j = 0; j < cnt; j++) if (lst[j] == b) used = 1;
        if (!used) begin freeP[nFree] = b; nFree++; end
      end
      for (int part = 0; part < (1 << (IDX_W - cnt)); part++) begin
        for (int e = 0; e < (1 << cnt); e++) begin
          gi[e] = 0;
          for (int j = 0; j < cnt; j++) gi[e] |= ((e >> j) & 1) << lst[j];
          for (int i = 0; i < nFree; i++) gi[e] |= ((part >> i) & 1) << freeP[i];
          v[e] = model[gi[e]];
          pushTxn(0, gi[e], 0);
        end
        for (int j = 0; j < cnt; j++) begin
          for (int q = 0; q < (1 << (cnt - 1)); q++) begin
            lo  = ((q >> j) << (j + 1)) | (q & ((1 << j) - 1));
            hi  = lo | (1 << j);
            asc = (stg >= IDX_W) || (((gi[lo] >> stg) & 1) == 0);
            if (asc ? (v[lo] > v[hi]) : (v[lo] < v[hi])) begin
              t = v[lo]; v[lo] = v[hi]; v[hi] = t;
            end
          end
        end
        for (int e = 0; e < (1 << cnt); e++) begin
          pushTxn(1, gi[e], v[e]);
          model[gi[e]] = v[e];
        end
      end
    end
    @(negedge clk);
    stage  = STG_W'(stg);
    cCount = CNT_W'(cnt);
    cList  = '0;
    for (int j = 0; j < LOC_W; j++) cList[j*POS_W +: POS_W] = POS_W'(lst[j]);
    start  = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    check(done, "R8", "done seen", int'(done), 1);
    if (cnt < 1 || cnt > LOC_W) begin
      check(txnCnt == base, "R2", "accesses on rejected list", txnCnt - base, 0);
      check(waitCyc == 0, "R2", "cycles to done", waitCyc, 0);
    end else begin
      check(expQ.size() == 0, "R7", "accesses still missing", expQ.size(), 0);
      check(txnCnt - base == 2 * NITEMS, "R7", "access count", txnCnt - base, 2 * NITEMS);
    end
    check(!memReq, "R8", "memReq during done", int'(memReq), 0);
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rstN   = 1'b0;
    start  = 1'b0;
    stage  = '0;
    cCount = '0;
    cList  = '0;
    for (int i = 0; i < NITEMS; i++) begin
      extMem[i] = DATA_W'(((i * 11 + 5) % 16) * 3 + 1);
      model[i]  = int'(extMem[i]);
    end
    repeat (3) @(negedge clk);
    check(!done, "R1", "done in reset", int'(done), 0);
    check(!memReq, "R1", "memReq in reset", int'(memReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done, "R1", "done after reset", int'(done), 0);
    check(!memReq, "R1", "memReq after reset", int'(memReq), 0);

    // R2: empty and oversized lists
    runSuper(4, 0, 0, 0, 0);
    runSuper(4, 4, 0, 1, 2);

    // R3 R6: scattered positions, direction set by a part bit
    runSuper(2, 2, 3, 1, 0);
    runSuper(1, 3, 2, 0, 3);
    // R5: list order differs from bit order, ascending stage
    runSuper(4, 2, 0, 2, 0);

    // R9: full sort from fresh data
    for (int i = 0; i < NITEMS; i++) begin
      extMem[i] = DATA_W'(((i * 7 + 9) % 16) * 5 + 2);
      model[i]  = int'(extMem[i]);
    end
    runSuper(1, 1, 0, 0, 0);
    runSuper(2, 2, 1, 0, 0);
    runSuper(3, 3, 2, 1, 0);
    runSuper(4, 1, 3, 0, 0);
    runSuper(4, 3, 2, 1, 0);
    for (int i = 0; i < NITEMS - 1; i++)
      check(extMem[i] <= extMem[i+1], "R9", "sorted order", int'(extMem[i]), int'(extMem[i+1]));
    finishRun();
  end
endmodule